// File: doc/BRIEF.md
# Two-Phase PWM Pin Driver

This block drives one output pin. In timer mode the pin carries a waveform whose high phase and low phase each have their own 16-bit length register. A stored value n gives a phase of n+1 ticks. A tick is any clock cycle on which the tick enable input is high, so the caller sets the time base by pulsing that input.

The same pin can also act as a static output driven low or high, or it can be released by deasserting its output enable. The mode is chosen by a 3-bit control word. Every write of the control word that selects timer mode starts the waveform again from the beginning of a high phase. Any write that selects another mode stops the timer and parks its counter at zero.

Phase lengths may be rewritten while the timer runs. Each phase takes its length when that phase begins, so a phase that is already in progress always runs to its full length.

Top module: `pwm_pin_ctl`

## Requirements
- R1: While reset is high, and after it until the first control write, pin_oe and pin_o are both 0.
- R2: The control word has three fields: bit 2 is the mode, bit 1 is the direction and bit 0 is the output level. When bit 2 is 1, pin_oe is 1 and pin_o follows the timer, whatever bits 1 and 0 hold.
- R3: When bit 2 is 0 and bit 1 is 1, pin_oe is 1 and pin_o equals bit 0 of the control word, steadily.
- R4: When bits 2 and 1 are both 0, pin_oe is 0 and pin_o is 0, for either value of bit 0.
- R5: With the tick enable held high, a high phase lasts HI+1 cycles and a low phase lasts LO+1 cycles. HI and LO are the values in the two length registers.
- R6: The timer advances only on cycles where tick_en is high. With tick_en high on every second cycle, each phase lasts twice as many cycles.
- R7: A control write that selects timer mode while the timer is already running restarts it with a full high phase of HI+1 ticks. The restart begins at the clock edge of the write.
- R8: A control write that leaves timer mode stops the timer. A later activation gives a full first high phase followed by a full low phase.
- R9: A length register write during a phase does not change that phase. The new value applies from the next phase of that type.
- R10: The outputs are registered. A control write sampled at clock edge E is visible on pin_o and pin_oe after edge E+1.
- R11: A length value of 0 gives a one-tick phase. The value 0xFFFF gives a 65536-tick phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Time-base enable; the timer counts only when this is high |
| hi_we | input | 1 | Write strobe for the high-phase length |
| lo_we | input | 1 | Write strobe for the low-phase length |
| len_wdata | input | 16 | Phase length value (n gives n+1 ticks) |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 3 | Control word: [2] mode, [1] direction, [0] level |
| pin_o | output | 1 | Pin value |
| pin_oe | output | 1 | Pin output enable |

## Verification
The hardest cases to reach from the ports are those where a write lands in the middle of a phase that is already running. These are a restart during a high phase and a length update during a high phase. Their effect shows only as a longer or shorter run of the pin, not as a value on any port. The stimulus therefore waits until it sees the pin rise and then places the write a fixed number of cycles into the phase. Each check counts the whole run of equal pin samples and compares it with the length the requirement predicts. The expected run differs clearly from the run a design without the restart rule, or one that applies updates at once, would produce.

// File: rtl/pwm_pin_pkg.sv
package pwm_pin_pkg;
  typedef struct packed {
    logic mode;   // bit 2: timer drives the pin
    logic dir;    // bit 1: static drive when mode is 0
    logic level;  // bit 0: static level
  } pin_ctl_t;

  localparam int CTL_W = $bits(pin_ctl_t);
endpackage

// File: rtl/pwm_len_regs.sv
module pwm_len_regs #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hi_we,
  input  logic             lo_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] hi_len,
  output logic [CNT_W-1:0] lo_len
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_len <= '0;
      lo_len <= '0;
    end else begin
      if (hi_we) hi_len <= wdata;
      if (lo_we) lo_len <= wdata;
    end
  end
endmodule

// File: rtl/pwm_phase_timer.sv
module pwm_phase_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] hi_len_i,
  input  logic [CNT_W-1:0] lo_len_i,
  output logic             phase_hi_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;
  logic             phase_q;
  logic             at_end;

  assign at_end     = (cnt_q == len_q);
  assign phase_hi_o = phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b1;
      cnt_q   <= '0;
      len_q   <= '0;
    end else if (restart_i) begin
      phase_q <= 1'b1;
      cnt_q   <= '0;
      len_q   <= hi_len_i;
    end else if (!run_i) begin
      phase_q <= 1'b1;
      cnt_q   <= '0;
    end else if (tick_i) begin
      if (at_end) begin
        phase_q <= ~phase_q;
        cnt_q   <= '0;
        len_q   <= phase_q ? lo_len_i : hi_len_i;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R5: the count never passes the length latched for the phase
  p_cnt_in_phase_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= len_q);

  // R6: no tick, no restart, still running -> nothing moves
  p_no_tick_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !restart_i && run_i) |=> ($stable(cnt_q) && $stable(phase_q)));

  // R8: a stopped timer parks at zero in the high phase
  p_stop_parks_r8: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !restart_i) |=> (cnt_q == '0 && phase_q));

  // R9: a phase only ends when its count is used up
  p_no_early_switch_r9: assert property (@(posedge clk) disable iff (rst)
    (run_i && !restart_i && !at_end) |=> (phase_q == $past(phase_q)));
endmodule

// File: rtl/pwm_pin_drive.sv
module pwm_pin_drive
  import pwm_pin_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  pin_ctl_t ctl_i,
  input  logic     phase_hi_i,
  output logic     pin_o,
  output logic     oe_o
);
  logic pin_d;
  logic oe_d;

  always_comb begin
    if (ctl_i.mode) begin
      oe_d  = 1'b1;
      pin_d = phase_hi_i;
    end else if (ctl_i.dir) begin
      oe_d  = 1'b1;
      pin_d = ctl_i.level;
    end else begin
      oe_d  = 1'b0;
      pin_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_o <= 1'b0;
      oe_o  <= 1'b0;
    end else begin
      pin_o <= pin_d;
      oe_o  <= oe_d;
    end
  end

  // R4: released pin is not driven and reads 0
  p_release_r4: assert property (@(posedge clk) disable iff (rst)
    (!ctl_i.mode && !ctl_i.dir) |=> (!oe_o && !pin_o));

  // R2: timer mode drives the timer phase one cycle later
  p_timer_drive_r2: assert property (@(posedge clk) disable iff (rst)
    ctl_i.mode |=> (oe_o && pin_o == $past(phase_hi_i)));

  // R3: static drive follows the level bit
  p_static_drive_r3: assert property (@(posedge clk) disable iff (rst)
    (!ctl_i.mode && ctl_i.dir) |=> (oe_o && pin_o == $past(ctl_i.level)));
endmodule

// File: rtl/pwm_pin_ctl.sv
module pwm_pin_ctl
  import pwm_pin_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             hi_we,
  input  logic             lo_we,
  input  logic [CNT_W-1:0] len_wdata,
  input  logic             ctl_we,
  input  logic [2:0]       ctl_wdata,
  output logic             pin_o,
  output logic             pin_oe
);
  localparam int CW = CTL_W;

  pin_ctl_t         ctl_q;
  pin_ctl_t         ctl_new;
  logic             restart;
  logic             phase_hi;
  logic [CNT_W-1:0] hi_len;
  logic [CNT_W-1:0] lo_len;

  assign ctl_new = pin_ctl_t'(ctl_wdata[CW-1:0]);
  assign restart = ctl_we && ctl_new.mode;

  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_new;
  end

  pwm_len_regs #(.CNT_W(CNT_W)) u_len (
    .clk    (clk),
    .rst    (rst),
    .hi_we  (hi_we),
    .lo_we  (lo_we),
    .wdata  (len_wdata),
    .hi_len (hi_len),
    .lo_len (lo_len)
  );

  pwm_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_en),
    .restart_i  (restart),
    .run_i      (ctl_q.mode),
    .hi_len_i   (hi_len),
    .lo_len_i   (lo_len),
    .phase_hi_o (phase_hi)
  );

  pwm_pin_drive u_drive (
    .clk        (clk),
    .rst        (rst),
    .ctl_i      (ctl_q),
    .phase_hi_i (phase_hi),
    .pin_o      (pin_o),
    .oe_o       (pin_oe)
  );

  // R7: an activating write always lands in a fresh high phase
  p_restart_high_r7: assert property (@(posedge clk) disable iff (rst)
    restart |=> phase_hi);

  // R10: outputs reflect a static control word two edges after its write
  p_latency_r10: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && !ctl_new.mode && !ctl_new.dir) |=> ##1 (!pin_oe || ctl_we || $past(ctl_we)));
endmodule

// File: tb/pwm_pin_ctl_tb.sv
module pwm_pin_ctl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b1;
  logic        gate = 1'b0;
  logic        hi_we = 1'b0;
  logic        lo_we = 1'b0;
  logic [15:0] len_wdata = '0;
  logic        ctl_we = 1'b0;
  logic [2:0]  ctl_wdata = '0;
  logic        pin_o;
  logic        pin_oe;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  pwm_pin_ctl u_dut (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .hi_we     (hi_we),
    .lo_we     (lo_we),
    .len_wdata (len_wdata),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .pin_o     (pin_o),
    .pin_oe    (pin_oe)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (gate) tick_en <= ~tick_en;
    else      tick_en <= 1'b1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic wr_ctl(input logic [2:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_len(input int hi, input int lo);
    @(negedge clk); hi_we = 1'b1; len_wdata = 16'(hi);
    @(negedge clk); hi_we = 1'b0; lo_we = 1'b1; len_wdata = 16'(lo);
    @(negedge clk); lo_we = 1'b0;
  endtask

  task automatic measure(output int hi, output int lo);
    int guard = 0;
    hi = 0; lo = 0;
    @(negedge clk);
    while (pin_o !== 1'b0 && guard < 70000) begin @(negedge clk); guard++; end
    while (pin_o !== 1'b1 && guard < 140000) begin @(negedge clk); guard++; end
    while (pin_o === 1'b1 && hi < 70000) begin hi++; @(negedge clk); end
    while (pin_o === 1'b0 && lo < 70000) begin lo++; @(negedge clk); end
  endtask

  task automatic count_level(input logic lvl, output int n);
    n = 0;
    while (pin_o === lvl && n < 70000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1 oe in reset", int'(pin_oe), 0);
    check("R1 pin in reset", int'(pin_o), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 oe after reset", int'(pin_oe), 0);
    check("R1 pin after reset", int'(pin_o), 0);
  endtask

  task automatic t_static;
    wr_ctl(3'b011);
    check("R10 old value one edge after write", int'(pin_oe), 0);
    @(negedge clk);
    check("R10 R3 oe static high", int'(pin_oe), 1);
    check("R3 pin static high", int'(pin_o), 1);
    repeat (20) @(negedge clk);
    check("R3 pin stays high", int'(pin_o), 1);
    wr_ctl(3'b010);
    @(negedge clk);
    check("R3 pin static low", int'(pin_o), 0);
    check("R3 oe static low", int'(pin_oe), 1);
  endtask

  task automatic t_release;
    wr_ctl(3'b001);
    @(negedge clk);
    check("R4 oe released level 1", int'(pin_oe), 0);
    check("R4 pin released level 1", int'(pin_o), 0);
    wr_ctl(3'b000);
    @(negedge clk);
    check("R4 oe released level 0", int'(pin_oe), 0);
  endtask

  task automatic t_basic;
    int h, l;
    wr_ctl(3'b010);
    wr_len(4, 2);
    wr_ctl(3'b100);
    measure(h, l);
    check("R5 high run", h, 5);
    check("R5 low run", l, 3);
    measure(h, l);
    check("R5 period", h + l, 8);
  endtask

  task automatic t_override;
    int h, l;
    wr_ctl(3'b010);
    wr_len(2, 3);
    wr_ctl(3'b111);
    measure(h, l);
    check("R2 111 high run", h, 3);
    check("R2 111 low run", l, 4);
    wr_ctl(3'b010);
    wr_ctl(3'b101);
    measure(h, l);
    check("R2 101 high run", h, 3);
    check("R2 oe in timer low phase", int'(pin_oe), 1);
  endtask

  task automatic t_reactivate;
    int n;
    wr_ctl(3'b010);
    wr_len(9, 9);
    wr_ctl(3'b100);
    @(negedge clk);
    while (pin_o !== 1'b1) @(negedge clk);
    repeat (2) @(negedge clk);
    wr_ctl(3'b100);
    count_level(1'b1, n);
    check("R7 high run after restart", n, 11);
    count_level(1'b0, n);
    check("R7 low run after restart", n, 10);
  endtask

  task automatic t_stop;
    int n;
    wr_len(4, 4);
    wr_ctl(3'b100);
    repeat (7) @(negedge clk);
    wr_ctl(3'b011);
    @(negedge clk);
    repeat (12) begin
      @(negedge clk);
      if (pin_o !== 1'b1) n = -1;
    end
    check("R8 stopped pin static", int'(pin_o), 1);
    wr_ctl(3'b100);
    count_level(1'b1, n);
    check("R8 first high after stop", n, 6);
    count_level(1'b0, n);
    check("R8 first low after stop", n, 5);
  endtask

  task automatic t_update;
    int h, l, n;
    wr_ctl(3'b010);
    wr_len(5, 5);
    wr_ctl(3'b100);
    @(negedge clk);
    while (pin_o !== 1'b1) @(negedge clk);
    h = 1;
    @(negedge clk);
    if (pin_o === 1'b1) h++;
    hi_we = 1'b1; len_wdata = 16'd2;
    @(negedge clk);
    if (pin_o === 1'b1) h++;
    hi_we = 1'b0; lo_we = 1'b1; len_wdata = 16'd8;
    @(negedge clk);
    lo_we = 1'b0;
    count_level(1'b1, n);
    check("R9 current high not cut", h + n, 6);
    count_level(1'b0, l);
    check("R9 new low applied", l, 9);
    count_level(1'b1, n);
    check("R9 new high applied", n, 3);
  endtask

  task automatic t_gated;
    int h, l;
    wr_ctl(3'b010);
    wr_len(3, 1);
    gate = 1'b1;
    wr_ctl(3'b100);
    measure(h, l);
    measure(h, l);
    check("R6 gated high run", h, 8);
    check("R6 gated low run", l, 4);
    gate = 1'b0;
  endtask

  task automatic t_extremes;
    int h, l;
    wr_ctl(3'b010);
    wr_len(65535, 0);
    wr_ctl(3'b100);
    measure(h, l);
    check("R11 max high run", h, 65536);
    check("R11 min low run", l, 1);
    wr_ctl(3'b010);
  endtask

  initial begin
    t_reset;
    t_static;
    t_release;
    t_basic;
    t_override;
    t_reactivate;
    t_stop;
    t_update;
    t_gated;
    t_extremes;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule